// File: doc/BRIEF.md
# Multi-channel level/edge trigger unit

This block watches a bank of sampled logic inputs and produces a single-cycle trigger pulse when every selected channel satisfies its condition on the same sample. A host arms the unit with a one-cycle pulse. The unit then judges each qualified sample, which is marked by a sample-valid strobe, until the trigger fires. Firing disarms the unit, so each arm produces at most one trigger.

Each channel is configured by one bit in each of four masks. The in-use mask names the channels that are wired and active, and a channel takes part only when it is both in use and enabled. The kind mask chooses a level test (bit set) or an edge test (bit clear). The sense mask chooses high or low for a level test, and falling or rising for an edge test. Edge tests compare the current sample with the last qualified sample.

Only one participating channel may use an edge test. A setup with more than one raises a configuration error flag, and the unit never fires while that flag is up.

Top module: `trig_unit`

## Requirements
- R1: After reset, `armed` and `trig_out` are 0.
- R2: An `arm` pulse sets `armed` on the next clock edge. `trig_out` can go high only for a sample taken while `armed` was already 1. It goes high for exactly one cycle, one clock after that sample, and `armed` falls on the same edge. A sample with no `arm` pulse after a trigger does not fire again.
- R3: A channel with its kind bit = 1 matches when its input equals its sense bit (sense 1 = high, sense 0 = low).
- R4: A channel with its kind bit = 0 matches a rising edge (previous 0, current 1) when its sense bit = 0, and a falling edge (previous 1, current 0) when its sense bit = 1.
- R5: The trigger needs all participating channels to match on the same sample (logical AND).
- R6: `cfg_error` is 1 whenever more than one participating channel has its kind bit = 0. While `cfg_error` is 1, no sample fires the trigger.
- R7: With no participating channel, the first valid sample after arming fires the trigger.
- R8: A channel whose in-use bit is 0 does not participate, whatever its enable, kind and sense bits. It counts neither toward matching nor toward the edge limit of R6.
- R9: No edge is seen on the first valid sample after reset, because no previous sample exists yet.
- R10: Inputs in cycles with `smp_valid` = 0 are ignored. They neither fire the trigger nor replace the previous sample used for edge tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_in_use | input | 16 | Channels that are wired and active |
| cfg_enable | input | 16 | Channels that take part in the trigger |
| cfg_kind | input | 16 | Per channel: 1 = level test, 0 = edge test |
| cfg_sense | input | 16 | Level: 1 = high, 0 = low. Edge: 1 = falling, 0 = rising |
| arm | input | 1 | One-cycle pulse that arms the unit |
| smp_valid | input | 1 | Marks a qualified sample on `smp_data` |
| smp_data | input | 16 | Sampled logic inputs |
| armed | output | 1 | Unit is waiting for a trigger |
| trig_out | output | 1 | One-cycle trigger pulse |
| cfg_error | output | 1 | More than one participating edge channel |

## Verification
The stored previous sample is the only hidden state besides the arm flag. If it is corrupted, or updated on a cycle without a strobe, an edge trigger appears or goes missing on the very next qualified sample, one clock later at `trig_out`. A stuck arm flag shows up either as a trigger on a sample taken before arming or after a trigger, or as no trigger on a sample that matches. A wrong per-channel decode shows up as a wrong `trig_out` one clock after a single qualified sample. The vector table therefore pairs a previous sample and a current sample for each condition type, and the directed tests aim at the strobe and arming windows.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned TRIG_NCH = 16;

  // Result for one channel. A channel that does not take part always agrees.
  function automatic logic chan_agrees(
    input logic part,
    input logic kind_level,
    input logic sense,
    input logic cur,
    input logic prev,
    input logic prev_ok
  );
    logic res;
    if (!part)
      res = 1'b1;
    else if (kind_level)
      res = (cur == sense);
    else if (!prev_ok)
      res = 1'b0;
    else if (sense)
      res = prev & ~cur;
    else
      res = ~prev & cur;
    return res;
  endfunction

  // True when more than one bit of the vector is set.
  function automatic logic several_set(input logic [TRIG_NCH-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction
endpackage

// File: rtl/trig_cfg_decode.sv
module trig_cfg_decode
  import trig_pkg::*;
#(
  parameter int unsigned NCH = TRIG_NCH
) (
  input  logic [NCH-1:0] in_use,
  input  logic [NCH-1:0] enable,
  input  logic [NCH-1:0] kind,
  output logic [NCH-1:0] part,
  output logic [NCH-1:0] edge_mask,
  output logic           cfg_err
);
  always_comb begin
    part      = enable & in_use;
    edge_mask = part & ~kind;
    cfg_err   = (edge_mask & (edge_mask - 1'b1)) != '0;
  end
endmodule

// File: rtl/trig_sample_hist.sv
module trig_sample_hist #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic [NCH-1:0] data,
  output logic [NCH-1:0] prev,
  output logic           prev_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= '0;
      prev_ok <= 1'b0;
    end else if (valid) begin
      prev    <= data;
      prev_ok <= 1'b1;
    end
  end

  // R10: the history only moves on a qualified sample
  a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(prev) && $stable(prev_ok));
endmodule

// File: rtl/trig_chan_eval.sv
module trig_chan_eval
  import trig_pkg::*;
#(
  parameter int unsigned NCH = TRIG_NCH
) (
  input  logic [NCH-1:0] part,
  input  logic [NCH-1:0] kind,
  input  logic [NCH-1:0] sense,
  input  logic [NCH-1:0] cur,
  input  logic [NCH-1:0] prev,
  input  logic           prev_ok,
  output logic [NCH-1:0] agree,
  output logic           all_agree
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign agree[i] = chan_agrees(part[i], kind[i], sense[i],
                                  cur[i], prev[i], prev_ok);
  end
  assign all_agree = &agree;
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int unsigned NCH = TRIG_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cfg_in_use,
  input  logic [NCH-1:0] cfg_enable,
  input  logic [NCH-1:0] cfg_kind,
  input  logic [NCH-1:0] cfg_sense,
  input  logic           arm,
  input  logic           smp_valid,
  input  logic [NCH-1:0] smp_data,
  output logic           armed,
  output logic           trig_out,
  output logic           cfg_error
);
  logic [NCH-1:0] part;
  logic [NCH-1:0] edge_mask;
  logic [NCH-1:0] prev;
  logic [NCH-1:0] agree;
  logic           prev_ok;
  logic           all_agree;
  logic           fire;

  trig_cfg_decode #(.NCH(NCH)) u_cfg (
    .in_use    (cfg_in_use),
    .enable    (cfg_enable),
    .kind      (cfg_kind),
    .part      (part),
    .edge_mask (edge_mask),
    .cfg_err   (cfg_error)
  );

  trig_sample_hist #(.NCH(NCH)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (smp_valid),
    .data    (smp_data),
    .prev    (prev),
    .prev_ok (prev_ok)
  );

  trig_chan_eval #(.NCH(NCH)) u_eval (
    .part      (part),
    .kind      (cfg_kind),
    .sense     (cfg_sense),
    .cur       (smp_data),
    .prev      (prev),
    .prev_ok   (prev_ok),
    .agree     (agree),
    .all_agree (all_agree)
  );

  assign fire = armed & smp_valid & all_agree & ~cfg_error;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      trig_out <= fire;
      if (fire)
        armed <= 1'b0;
      else if (arm)
        armed <= 1'b1;
    end
  end

  // R2: the pulse lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
  // R2: firing leaves the unit disarmed
  a_r2_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> !armed);
  // R2: a pulse follows an armed, qualified sample
  a_r2_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> $past(smp_valid) && $past(armed));
  // R6: a bad setup never fires
  a_r6_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error && smp_valid |=> !trig_out);
  // R5: a channel that disagrees blocks the trigger
  a_r5_and_all: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (agree != '1) |=> !trig_out);
  // R6: one edge channel at most when no error is flagged
  a_r6_edge_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_error |-> $onehot0(edge_mask));
endmodule

// File: tb/tb_trig_unit.sv
module tb_trig_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_use = '1, en = '0, kind = '0, sense = '0;
  logic        arm = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        armed, trig_out, cfg_error;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  trig_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_in_use(in_use), .cfg_enable(en),
    .cfg_kind(kind), .cfg_sense(sense), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .armed(armed), .trig_out(trig_out),
    .cfg_error(cfg_error)
  );

  // fields: in_use, enable, kind, sense, previous sample, current sample, fire, error
  localparam int NV = 15;
  localparam logic [97:0] TBL [NV] = '{
    {16'hffff, 16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0001, 1'b1, 1'b0}, // R3 high
    {16'hffff, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0000, 1'b0, 1'b0}, // R3 high miss
    {16'hffff, 16'h0020, 16'h0020, 16'h0000, 16'h0020, 16'h0000, 1'b1, 1'b0}, // R3 low
    {16'hffff, 16'h0020, 16'h0020, 16'h0000, 16'h0000, 16'h0020, 1'b0, 1'b0}, // R3 low miss
    {16'hffff, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0008, 1'b1, 1'b0}, // R4 rising
    {16'hffff, 16'h0008, 16'h0000, 16'h0000, 16'h0008, 16'h0008, 1'b0, 1'b0}, // R4 steady
    {16'hffff, 16'h8000, 16'h0000, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b0}, // R4 falling
    {16'hffff, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 1'b0, 1'b0}, // R4 wrong way
    {16'hffff, 16'h0303, 16'h0303, 16'h0101, 16'h0000, 16'h0101, 1'b1, 1'b0}, // R5 all
    {16'hffff, 16'h0303, 16'h0303, 16'h0101, 16'h0000, 16'h0301, 1'b0, 1'b0}, // R5 one off
    {16'hffff, 16'h0011, 16'h0001, 16'h0001, 16'h0001, 16'h0011, 1'b1, 1'b0}, // R5 level+edge
    {16'hffff, 16'h0011, 16'h0000, 16'h0000, 16'h0000, 16'h0011, 1'b0, 1'b1}, // R6 two edges
    {16'h00ff, 16'h0101, 16'h0101, 16'h0101, 16'h0000, 16'h0001, 1'b1, 1'b0}, // R8 ignored ch
    {16'hffff, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h4321, 1'b1, 1'b0}, // R7 none
    {16'h0001, 16'h0011, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 1'b1, 1'b0}  // R8 edge count
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; arm = 1'b0; smp_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic sample(input logic [15:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_data = d; arm = 1'b0;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk({15'd0, armed}, 16'd0, "R1 armed after reset");
    chk({15'd0, trig_out}, 16'd0, "R1 trig after reset");
    rst_n = 1'b1;

    // Table walk: one previous sample, arm, one judged sample
    for (int i = 0; i < NV; i++) begin
      in_use = TBL[i][97:82]; en = TBL[i][81:66];
      kind = TBL[i][65:50]; sense = TBL[i][49:34];
      do_reset();
      sample(TBL[i][33:18]);
      pulse_arm();
      chk({15'd0, armed}, 16'd1, $sformatf("R2 armed vec %0d", i));
      chk({15'd0, cfg_error}, {15'd0, TBL[i][0]}, $sformatf("R6 error flag vec %0d", i));
      @(negedge clk); smp_valid = 1'b1; smp_data = TBL[i][17:2];
      @(negedge clk); smp_valid = 1'b0;
      chk({15'd0, trig_out}, {15'd0, TBL[i][1]}, $sformatf("R3/R4/R5 fire vec %0d", i));
      chk({15'd0, armed}, {15'd0, ~TBL[i][1]}, $sformatf("R2 disarm vec %0d", i));
    end

    // R2: one-cycle pulse, no refire without arm
    in_use = '1; en = 16'h0001; kind = 16'h0001; sense = 16'h0001;
    do_reset(); pulse_arm(); sample(16'h0001);
    chk({15'd0, trig_out}, 16'd1, "R2 fires");
    @(negedge clk);
    chk({15'd0, trig_out}, 16'd0, "R2 pulse one cycle");
    sample(16'h0001);
    chk({15'd0, trig_out}, 16'd0, "R2 no refire unarmed");

    // R2: sample before arming does not fire
    do_reset(); sample(16'h0001);
    chk({15'd0, trig_out}, 16'd0, "R2 unarmed sample");

    // R9: first sample after reset has no history
    en = 16'h0001; kind = 16'h0000; sense = 16'h0000;
    do_reset(); pulse_arm(); sample(16'h0001);
    chk({15'd0, trig_out}, 16'd0, "R9 no edge on first sample");
    sample(16'h0000); sample(16'h0001);
    chk({15'd0, trig_out}, 16'd1, "R9 edge after history");

    // R10: invalid cycles neither fire nor touch history
    do_reset(); sample(16'h0000); pulse_arm();
    @(negedge clk); smp_data = 16'h0001; smp_valid = 1'b0;
    @(negedge clk);
    chk({15'd0, trig_out}, 16'd0, "R10 invalid no fire");
    sample(16'h0001);
    chk({15'd0, trig_out}, 16'd1, "R10 history kept");

    // R6: error holds off firing across several samples
    en = 16'h0003; kind = 16'h0000;
    do_reset(); sample(16'h0000); pulse_arm();
    sample(16'h0001); sample(16'h0000); sample(16'h0003);
    chk({15'd0, trig_out}, 16'd0, "R6 no fire with error");
    chk({15'd0, armed}, 16'd1, "R6 stays armed");

    // R7: no channel, first valid sample after arm fires
    en = 16'h0000;
    do_reset(); pulse_arm();
    @(negedge clk); @(negedge clk);
    chk({15'd0, trig_out}, 16'd0, "R7 waits for strobe");
    sample(16'hbeef);
    chk({15'd0, trig_out}, 16'd1, "R7 fires on first sample");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule